// File: doc/BRIEF.md
# Vector Floating-Point Scalar Move Unit

This unit handles the two scalar moves between the vector register file and the floating-point register file. The first reads element 0 of a vector register and writes it into a 64-bit floating-point register. The second reads a floating-point register and writes it into element 0 of a vector register. The unit decodes the instruction word and checks legality against the vector configuration and the floating-point enables. It then applies the width-dependent NaN-boxing or NaN-narrowing and drives one write port on each register file.

Decode and data shaping are combinational. Read indices go out in the same cycle as the instruction, and the read data is sampled on that cycle's edge. The write strobes, the write data and the illegal-instruction flag are registered, so they appear for exactly one cycle after an instruction is presented with its valid strobe. SEW is given as a code: 0 means 8 bits, 1 means 16, 2 means 32 and 3 means 64. FLEN is 64 when double precision is enabled and 32 when it is not.

Top module: `fpScalarMoveUnit`

## Requirements
- R1: The move-to-FP form has instWord[6:0]=1010111, [31:26]=010000, [25]=1, [14:12]=001 and [19:15]=0. It reads vector register [24:20] and writes FP register [11:7]. The move-to-vector form is the same except [14:12]=101 and [24:20]=0; it reads FP register [19:15] and writes vector register [11:7]. fprRdIdx is instWord[19:15] and vecRdIdx is instWord[24:20], both combinational. Any other word causes no write and no illegal flag.
- R2: Write enables and illegalInst are high for exactly the one cycle after the edge that sampled instValid=1. They are low in every other cycle.
- R3: A recognised move is illegal, and writes nothing, when vecCfgBad=1, when spEnable=0, or when sewCode=0.
- R4: A move-to-FP is also illegal when fpStatus=00. A successful move-to-FP raises fpDirtySet together with fprWrEn.
- R5: A move-to-FP writes element 0 with every bit at or above SEW set to 1. With SEW 64 the element is copied unchanged.
- R6: A legal move-to-vector with vlLen=0 writes nothing and is not illegal. A move-to-FP does not depend on vlLen.
- R7: A move-to-vector with SEW 64 and dpEnable=0 writes the low 32 bits of the FP register with bits [63:32] set to 1.
- R8: When SEW is below FLEN, the FP register value is narrowed. If all of its bits from SEW up to FLEN-1 are 1, the low SEW bits pass. Otherwise the result is the canonical quiet NaN: 0x7E00 for 16 bits, 0x7FC00000 for 32 bits.
- R9: When SEW equals FLEN (SEW 32 without double, or SEW 64 with double), the FP register's low SEW bits are copied unchanged.
- R10: A vector write touches only element 0. vecWrByteEn is 0x03, 0x0F or 0xFF for SEW 16, 32 or 64, and vecWrData bits above SEW are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction word is valid this cycle |
| instWord | input | 32 | Instruction word |
| sewCode | input | 2 | Element width code (0:8, 1:16, 2:32, 3:64 bits) |
| vlLen | input | VL_W | Current vector length |
| vecCfgBad | input | 1 | Vector configuration invalid flag |
| fpStatus | input | 2 | FP state field (00 = off) |
| spEnable | input | 1 | Single precision enabled |
| dpEnable | input | 1 | Double precision enabled |
| fprRdIdx | output | 5 | FP register read index |
| fprRdData | input | 64 | FP register read data |
| vecRdIdx | output | 5 | Vector register read index |
| vecElem0 | input | 64 | Element 0 of the read vector register (low SEW bits valid) |
| fprWrEn | output | 1 | FP register write enable |
| fprWrIdx | output | 5 | FP register write index |
| fprWrData | output | 64 | FP register write data |
| fpDirtySet | output | 1 | Request to mark FP state dirty |
| vecWrEn | output | 1 | Vector element 0 write enable |
| vecWrIdx | output | 5 | Vector register write index |
| vecWrData | output | 64 | Element 0 write data |
| vecWrByteEn | output | 8 | Byte enables within element 0 |
| illegalInst | output | 1 | Illegal instruction flag |

## Verification
The hardest path to reach is the failing branch of narrowing. It needs a move-to-vector with SEW below FLEN and an FP register whose bits above SEW are all ones except one. When double precision is off, that register must also carry arbitrary upper-half bits, which must be ignored. The stimulus builds such values on purpose: a single cleared bit just above the target width, plus junk in bits [63:32] with dpEnable low. These are mixed with properly boxed values under every SEW and double-precision setting. A behavioural model predicts every output on every cycle.

// File: rtl/fsmvPkg.sv
package fsmvPkg;
  localparam int DATA_W = 64;
  localparam int IDX_W  = 5;
  localparam int BYTE_W = DATA_W / 8;

  localparam logic [6:0] OPC_VEC  = 7'b1010111;
  localparam logic [5:0] F6_MOVE  = 6'b010000;
  localparam logic [2:0] F3_TOFPR = 3'b001;
  localparam logic [2:0] F3_TOVEC = 3'b101;
  localparam logic [1:0] FS_OFF   = 2'b00;

  typedef enum logic [1:0] {
    SEW_E8  = 2'd0,
    SEW_E16 = 2'd1,
    SEW_E32 = 2'd2,
    SEW_E64 = 2'd3
  } sewCode_e;

  typedef struct packed {
    logic             toFpr;
    logic             toVec;
    sewCode_e         sew;
    logic             dpOn;
    logic [IDX_W-1:0] dstIdx;
  } moveStrobes_t;
endpackage

// File: rtl/fsmvNanNarrow.sv
module fsmvNanNarrow #(
  parameter int DATA_W = 64,
  parameter int OUT_W  = 16
) (
  input  logic [DATA_W-1:0] srcVal,
  output logic [DATA_W-1:0] narrowVal
);
  localparam int EXP_W = (OUT_W == 16) ? 5 : (OUT_W == 32) ? 8 : 11;
  localparam logic [OUT_W-1:0] CANON_QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(OUT_W-EXP_W-2){1'b0}}};

  logic boxOk;
  assign boxOk = &srcVal[DATA_W-1:OUT_W];

  always_comb begin
    narrowVal = '0;
    narrowVal[OUT_W-1:0] = boxOk ? srcVal[OUT_W-1:0] : CANON_QNAN;
  end
endmodule

// File: rtl/fsmvCtrl.sv
module fsmvCtrl
  import fsmvPkg::*;
#(
  parameter int VL_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instValid,
  input  logic [31:0]        instWord,
  input  logic [1:0]         sewCode,
  input  logic [VL_W-1:0]    vlLen,
  input  logic               vecCfgBad,
  input  logic [1:0]         fpStatus,
  input  logic               spEnable,
  input  logic               dpEnable,
  output moveStrobes_t       stb,
  output logic               fprWrEn,
  output logic               fpDirtySet,
  output logic               vecWrEn,
  output logic               illegalInst
);
  logic isOpv, isToFpr, isToVec, cfgBad, fsOff, illNext;

  always_comb begin
    isOpv   = (instWord[6:0] == OPC_VEC) && (instWord[31:26] == F6_MOVE) && instWord[25];
    isToFpr = isOpv && (instWord[14:12] == F3_TOFPR) && (instWord[19:15] == '0);
    isToVec = isOpv && (instWord[14:12] == F3_TOVEC) && (instWord[24:20] == '0);
    cfgBad  = vecCfgBad || !spEnable || (sewCode == SEW_E8);
    fsOff   = (fpStatus == FS_OFF);
    illNext = instValid && ((isToFpr && (cfgBad || fsOff)) || (isToVec && cfgBad));

    stb.toFpr  = instValid && isToFpr && !cfgBad && !fsOff;
    stb.toVec  = instValid && isToVec && !cfgBad && (vlLen != '0);
    stb.sew    = sewCode_e'(sewCode);
    stb.dpOn   = dpEnable;
    stb.dstIdx = instWord[11:7];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fprWrEn     <= 1'b0;
      vecWrEn     <= 1'b0;
      illegalInst <= 1'b0;
    end else begin
      fprWrEn     <= stb.toFpr;
      vecWrEn     <= stb.toVec;
      illegalInst <= illNext;
    end
  end

  assign fpDirtySet = fprWrEn;

  // R3: at most one outcome per instruction
  assert_one_action_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({fprWrEn, vecWrEn, illegalInst}));
  // R2: every outcome follows a valid strobe
  assert_follows_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fprWrEn || vecWrEn || illegalInst) |-> $past(instValid));
  // R4: an FP write never happens with FP state off
  assert_fs_on_R4: assert property (@(posedge clk) disable iff (!rstN)
    fprWrEn |-> ($past(fpStatus) != 2'b00));
  // R6: a vector write needs a nonzero vector length
  assert_vl_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    vecWrEn |-> ($past(vlLen) != '0));
endmodule

// File: rtl/fsmvDatapath.sv
module fsmvDatapath
  import fsmvPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  moveStrobes_t      stb,
  input  logic [DATA_W-1:0] fprRdData,
  input  logic [DATA_W-1:0] vecElem0,
  output logic [IDX_W-1:0]  fprWrIdx,
  output logic [DATA_W-1:0] fprWrData,
  output logic [IDX_W-1:0]  vecWrIdx,
  output logic [DATA_W-1:0] vecWrData,
  output logic [BYTE_W-1:0] vecWrByteEn
);
  localparam int NARROW_N = 2;

  logic [DATA_W-1:0] boxSrc;
  logic [DATA_W-1:0] narrowPad [NARROW_N];
  logic [DATA_W-1:0] fprVal, vecVal;
  logic [BYTE_W-1:0] byteVal;

  // Without double support only the low 32 bits are architecturally held.
  assign boxSrc = stb.dpOn ? fprRdData : {{(DATA_W-32){1'b1}}, fprRdData[31:0]};

  for (genvar gi = 0; gi < NARROW_N; gi++) begin : gNarrow
    fsmvNanNarrow #(.DATA_W(DATA_W), .OUT_W(16 << gi)) uNarrow (
      .srcVal   (boxSrc),
      .narrowVal(narrowPad[gi])
    );
  end

  always_comb begin
    fprVal  = vecElem0;
    vecVal  = '0;
    byteVal = '0;
    unique case (stb.sew)
      SEW_E16: begin
        fprVal  = {{(DATA_W-16){1'b1}}, vecElem0[15:0]};
        vecVal  = narrowPad[0];
        byteVal = BYTE_W'(8'h03);
      end
      SEW_E32: begin
        fprVal  = {{(DATA_W-32){1'b1}}, vecElem0[31:0]};
        vecVal  = narrowPad[1];
        byteVal = BYTE_W'(8'h0F);
      end
      SEW_E64: begin
        fprVal  = vecElem0;
        vecVal  = boxSrc;
        byteVal = '1;
      end
      default: begin
        fprVal  = vecElem0;
        vecVal  = '0;
        byteVal = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fprWrIdx    <= '0;
      fprWrData   <= '0;
      vecWrIdx    <= '0;
      vecWrData   <= '0;
      vecWrByteEn <= '0;
    end else begin
      if (stb.toFpr) begin
        fprWrIdx  <= stb.dstIdx;
        fprWrData <= fprVal;
      end
      if (stb.toVec) begin
        vecWrIdx    <= stb.dstIdx;
        vecWrData   <= vecVal;
        vecWrByteEn <= byteVal;
      end
    end
  end
endmodule

// File: rtl/fpScalarMoveUnit.sv
module fpScalarMoveUnit
  import fsmvPkg::*;
#(
  parameter int VL_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [31:0]       instWord,
  input  logic [1:0]        sewCode,
  input  logic [VL_W-1:0]   vlLen,
  input  logic              vecCfgBad,
  input  logic [1:0]        fpStatus,
  input  logic              spEnable,
  input  logic              dpEnable,
  output logic [4:0]        fprRdIdx,
  input  logic [63:0]       fprRdData,
  output logic [4:0]        vecRdIdx,
  input  logic [63:0]       vecElem0,
  output logic              fprWrEn,
  output logic [4:0]        fprWrIdx,
  output logic [63:0]       fprWrData,
  output logic              fpDirtySet,
  output logic              vecWrEn,
  output logic [4:0]        vecWrIdx,
  output logic [63:0]       vecWrData,
  output logic [7:0]        vecWrByteEn,
  output logic              illegalInst
);
  moveStrobes_t stb;

  assign fprRdIdx = instWord[19:15];
  assign vecRdIdx = instWord[24:20];

  fsmvCtrl #(.VL_W(VL_W)) uCtrl (
    .clk, .rstN, .instValid, .instWord, .sewCode, .vlLen, .vecCfgBad,
    .fpStatus, .spEnable, .dpEnable, .stb,
    .fprWrEn, .fpDirtySet, .vecWrEn, .illegalInst
  );

  fsmvDatapath uData (
    .clk, .rstN, .stb, .fprRdData, .vecElem0,
    .fprWrIdx, .fprWrData, .vecWrIdx, .vecWrData, .vecWrByteEn
  );

  // R5: 16-bit element reaches the FP register NaN-boxed
  assert_fpr_box16_R5: assert property (@(posedge clk) disable iff (!rstN)
    (fprWrEn && $past(sewCode) == 2'd1) |-> (&fprWrData[63:16]));
  // R7: 64-bit element without double support has ones on top
  assert_dp_off_box_R7: assert property (@(posedge clk) disable iff (!rstN)
    (vecWrEn && $past(sewCode) == 2'd3 && !$past(dpEnable)) |-> (&vecWrData[63:32]));
  // R10: a 16-bit element write leaves the upper bits clear
  assert_elem0_only_R10: assert property (@(posedge clk) disable iff (!rstN)
    (vecWrEn && vecWrByteEn == 8'h03) |-> (vecWrData[63:16] == '0));
endmodule

// File: tb/tb_fpScalarMoveUnit.sv
module tb_fpScalarMoveUnit;
  localparam int VL_W = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, instValid, vecCfgBad, spEnable, dpEnable;
  logic [31:0] instWord;
  logic [1:0] sewCode, fpStatus;
  logic [VL_W-1:0] vlLen;
  logic [63:0] fprRdData, vecElem0;
  logic [4:0] fprRdIdx, vecRdIdx, fprWrIdx, vecWrIdx;
  logic fprWrEn, fpDirtySet, vecWrEn, illegalInst;
  logic [63:0] fprWrData, vecWrData;
  logic [7:0] vecWrByteEn;

  fpScalarMoveUnit #(.VL_W(VL_W)) dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  logic eFprEn, eVecEn, eIll;
  logic [4:0] eFprIdx, eVecIdx;
  logic [63:0] eFprData, eVecData;
  logic [7:0] eMask;

  function automatic logic [31:0] mkToFpr(logic [4:0] vs2, logic [4:0] rd);
    return {6'b010000, 1'b1, vs2, 5'b00000, 3'b001, rd, 7'b1010111};
  endfunction
  function automatic logic [31:0] mkToVec(logic [4:0] rs1, logic [4:0] vd);
    return {6'b010000, 1'b1, 5'b00000, rs1, 3'b101, vd, 7'b1010111};
  endfunction

  task automatic fail(string tag, string what, logic [63:0] act, logic [63:0] exp);
    fails++;
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) fail(tag, what, act, exp);
  endtask

  // Behavioural prediction of the registered outputs
  task automatic predict();
    int w;
    bit isF, isV, bad, ok;
    int flen;
    w   = 8 << sewCode;
    isF = instWord[6:0] == 7'b1010111 && instWord[31:26] == 6'b010000 && instWord[25]
          && instWord[14:12] == 3'b001 && instWord[19:15] == 0;
    isV = instWord[6:0] == 7'b1010111 && instWord[31:26] == 6'b010000 && instWord[25]
          && instWord[14:12] == 3'b101 && instWord[24:20] == 0;
    bad = vecCfgBad || !spEnable || sewCode == 0;
    eFprEn = 0; eVecEn = 0; eIll = 0;
    eFprIdx = 'x; eVecIdx = 'x; eFprData = 'x; eVecData = 'x; eMask = 'x;
    if (instValid && isF) begin
      if (bad || fpStatus == 0) eIll = 1;
      else begin
        eFprEn = 1; eFprIdx = instWord[11:7]; eFprData = vecElem0;
        for (int b = w; b < 64; b++) eFprData[b] = 1'b1;
      end
    end
    if (instValid && isV) begin
      if (bad) eIll = 1;
      else if (vlLen != 0) begin
        eVecEn = 1; eVecIdx = instWord[11:7];
        flen = dpEnable ? 64 : 32;
        eMask = (w == 16) ? 8'h03 : (w == 32) ? 8'h0F : 8'hFF;
        if (w < flen) begin
          ok = 1;
          for (int b = w; b < flen; b++) if (!fprRdData[b]) ok = 0;
          if (ok) begin
            eVecData = 0;
            for (int b = 0; b < w; b++) eVecData[b] = fprRdData[b];
          end else eVecData = (w == 16) ? 64'h7E00 : 64'h7FC00000;
        end else if (w == 64 && !dpEnable) eVecData = {32'hFFFFFFFF, fprRdData[31:0]};
        else begin
          eVecData = 0;
          for (int b = 0; b < w; b++) eVecData[b] = fprRdData[b];
        end
      end
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "fprWrEn", 64'(fprWrEn), 64'(eFprEn));
    chk("R4", "fpDirtySet", 64'(fpDirtySet), 64'(eFprEn));
    chk(tag, "vecWrEn", 64'(vecWrEn), 64'(eVecEn));
    chk(tag, "illegalInst", 64'(illegalInst), 64'(eIll));
    if (eFprEn) begin
      chk(tag, "fprWrIdx", 64'(fprWrIdx), 64'(eFprIdx));
      chk(tag, "fprWrData", fprWrData, eFprData);
    end
    if (eVecEn) begin
      chk(tag, "vecWrIdx", 64'(vecWrIdx), 64'(eVecIdx));
      chk(tag, "vecWrData", vecWrData, eVecData);
      chk("R10", "vecWrByteEn", 64'(vecWrByteEn), 64'(eMask));
    end
  endtask

  // Drive one cycle of stimulus and compare the next cycle's outputs.
  task automatic step(logic v, logic [31:0] iw, logic [1:0] sew, logic [VL_W-1:0] vl,
                      logic vill, logic [1:0] fs, logic sp, logic dp,
                      logic [63:0] fpr, logic [63:0] elem, string tag);
    instValid = v; instWord = iw; sewCode = sew; vlLen = vl; vecCfgBad = vill;
    fpStatus = fs; spEnable = sp; dpEnable = dp; fprRdData = fpr; vecElem0 = elem;
    #1;
    chk("R1", "fprRdIdx", 64'(fprRdIdx), 64'(iw[19:15]));
    chk("R1", "vecRdIdx", 64'(vecRdIdx), 64'(iw[24:20]));
    predict();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] junk;
    rstN = 0; instValid = 0; instWord = 0; sewCode = 2; vlLen = 4; vecCfgBad = 0;
    fpStatus = 1; spEnable = 1; dpEnable = 1; fprRdData = 0; vecElem0 = 0;
    repeat (3) @(negedge clk);
    chk("R2", "reset fprWrEn", 64'(fprWrEn), 0);
    chk("R2", "reset vecWrEn", 64'(vecWrEn), 0);
    chk("R2", "reset illegalInst", 64'(illegalInst), 0);
    rstN = 1;
    @(negedge clk);

    // R5: move to FP with each width
    step(1, mkToFpr(5'd3, 5'd9),  2'd1, 4, 0, 2'd1, 1, 1, 0, 64'h1234_5678_9ABC_DEF0, "R5");
    step(1, mkToFpr(5'd4, 5'd10), 2'd2, 4, 0, 2'd3, 1, 1, 0, 64'h1234_5678_9ABC_DEF0, "R5");
    step(1, mkToFpr(5'd5, 5'd11), 2'd3, 4, 0, 2'd2, 1, 1, 0, 64'h1234_5678_9ABC_DEF0, "R5");
    step(1, mkToFpr(5'd5, 5'd12), 2'd2, 4, 0, 2'd1, 1, 0, 0, 64'h0000_0000_3F80_0000, "R5");
    // R2: idle cycle produces nothing
    step(0, mkToFpr(5'd5, 5'd12), 2'd2, 4, 0, 2'd1, 1, 1, 0, 64'h1, "R2");
    // R3 / R4: illegal cases
    step(1, mkToFpr(5'd1, 5'd2), 2'd2, 4, 1, 2'd1, 1, 1, 0, 0, "R3");
    step(1, mkToVec(5'd1, 5'd2), 2'd2, 4, 0, 2'd1, 0, 1, 0, 0, "R3");
    step(1, mkToVec(5'd1, 5'd2), 2'd0, 4, 0, 2'd1, 1, 1, 0, 0, "R3");
    step(1, mkToFpr(5'd1, 5'd2), 2'd2, 4, 0, 2'd0, 1, 1, 0, 0, "R4");
    step(1, mkToVec(5'd1, 5'd2), 2'd2, 4, 0, 2'd0, 1, 1, 64'hFFFF_FFFF_4000_0000, 0, "R4");
    // R6: vl of zero
    step(1, mkToVec(5'd7, 5'd8), 2'd2, 0, 0, 2'd1, 1, 1, 64'hFFFF_FFFF_4000_0000, 0, "R6");
    step(1, mkToFpr(5'd7, 5'd8), 2'd2, 0, 0, 2'd1, 1, 1, 0, 64'h4040_0000, "R6");
    // R7: SEW 64 without double
    step(1, mkToVec(5'd6, 5'd1), 2'd3, 2, 0, 2'd1, 1, 0, 64'h0123_4567_89AB_CDEF, 0, "R7");
    // R8: narrowing good and bad
    step(1, mkToVec(5'd6, 5'd1), 2'd1, 2, 0, 2'd1, 1, 1, 64'hFFFF_FFFF_FFFF_3C00, 0, "R8");
    step(1, mkToVec(5'd6, 5'd1), 2'd1, 2, 0, 2'd1, 1, 1, 64'hFFFF_FFFF_FFFE_3C00, 0, "R8");
    step(1, mkToVec(5'd6, 5'd1), 2'd2, 2, 0, 2'd1, 1, 1, 64'hFFFF_FFFF_3F80_0000, 0, "R8");
    step(1, mkToVec(5'd6, 5'd1), 2'd2, 2, 0, 2'd1, 1, 1, 64'h7FFF_FFFF_3F80_0000, 0, "R8");
    step(1, mkToVec(5'd6, 5'd1), 2'd1, 2, 0, 2'd1, 1, 0, 64'h1234_5678_FFFF_3C00, 0, "R8");
    step(1, mkToVec(5'd6, 5'd1), 2'd1, 2, 0, 2'd1, 1, 0, 64'h1234_5678_FFEF_3C00, 0, "R8");
    // R9: equal widths copy unchanged
    step(1, mkToVec(5'd6, 5'd1), 2'd2, 2, 0, 2'd1, 1, 0, 64'h1234_5678_3F80_0001, 0, "R9");
    step(1, mkToVec(5'd6, 5'd1), 2'd3, 2, 0, 2'd1, 1, 1, 64'h0123_4567_89AB_CDEF, 0, "R9");
    // R1: near-miss encodings are ignored
    step(1, mkToFpr(5'd1, 5'd2) | 32'h0000_8000, 2'd2, 4, 0, 2'd1, 1, 1, 0, 0, "R1");
    step(1, mkToVec(5'd1, 5'd2) | 32'h0010_0000, 2'd2, 4, 0, 2'd1, 1, 1, 0, 0, "R1");
    step(1, mkToVec(5'd1, 5'd2) & ~32'h0200_0000, 2'd2, 4, 1, 2'd1, 1, 1, 0, 0, "R1");
    step(1, mkToFpr(5'd1, 5'd2) ^ 32'h0000_0001, 2'd2, 4, 1, 2'd1, 1, 1, 0, 0, "R1");

    // Mixed patterns, R10 on every vector write
    for (int i = 0; i < 600; i++) begin
      logic [31:0] iw;
      logic [63:0] fpr;
      int kind, wsel;
      kind = $urandom_range(0, 5);
      if (kind < 2) iw = mkToFpr(5'($urandom), 5'($urandom));
      else if (kind < 4) iw = mkToVec(5'($urandom), 5'($urandom));
      else if (kind == 4) iw = mkToVec(5'($urandom), 5'($urandom)) ^ (32'd1 << $urandom_range(0, 31));
      else iw = $urandom;
      junk = {$urandom, $urandom};
      wsel = $urandom_range(0, 3);
      fpr = junk;
      if (wsel == 1) fpr = {48'hFFFF_FFFF_FFFF, junk[15:0]};
      else if (wsel == 2) fpr = {32'hFFFF_FFFF, junk[31:0]};
      else if (wsel == 3) fpr = {48'hFFFF_FFFF_FFFF, junk[15:0]} ^ (64'd1 << $urandom_range(16, 40));
      step($urandom_range(0, 7) != 0, iw, 2'($urandom), VL_W'($urandom_range(0, 3)),
           $urandom_range(0, 9) == 0, 2'($urandom), $urandom_range(0, 9) != 0,
           1'($urandom), fpr, {$urandom, $urandom}, "R10");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule